// File: doc/BRIEF.md
# Clock synthesizer mode controller

This block holds the control register and mode sequencing for a clock synthesizer that runs either in bypass or in lock mode. In bypass mode the output clock is the reference clock divided by 1, 2 or 4. In lock mode the output is meant to be the reference scaled by m/n. That synthesized clock arrives on an input pin from an oscillator outside the block. A reference-cycle counter of programmable length models the time the oscillator needs to acquire lock.

Software writes one control word holding the enable bit, the bypass divider, m and n, and reads it back with the lock flag added. It may use the output straight away. The output stays on the divided reference until lock is reported, then moves to the synthesized clock through a break-before-make gate sequence. Neither clock is ever cut short. An idle request stops the output and clears lock mode. When idle is released the block restarts in bypass mode and the output is valid again within a bounded number of reference cycles.

Top module: `pllc_top`

## Requirements
- R1: After reset the readback word is 0x108 (enable 0, bypass divider 0, m 1, n 1, lock 0) and clk_o runs at the reference rate. The word layout is: bit 0 enable, bits 2:1 bypass divider, bits 7:3 m, bits 10:8 n, bit 11 lock (read only).
- R2: In bypass mode, bypass divider 00 gives the reference rate on clk_o, 01 gives half the rate, and 1x gives a quarter of the rate.
- R3: A written m of 0 is stored as 1. A written n of 0 is stored as 1, and a written n above 4 is stored as 4.
- R4: After a write that sets the enable bit, lock_o and readback bit 11 stay 0 for LOCK_CYCLES reference cycles. They read 1 from the edge LOCK_CYCLES cycles after the write edge.
- R5: Once lock is reported, clk_o carries only the synthesized clock.
- R6: Every accepted write with the enable bit set clears lock on the next cycle and restarts the acquisition count. This includes rewriting m and n while already locked.
- R7: A write that clears the enable bit drops lock on the next cycle, and clk_o returns to the divided reference.
- R8: The bypass gate and the synthesized-clock gate are never open at the same time.
- R9: While idle_i is high, lock and the enable bit are cleared, register writes are ignored, and clk_o stays low.
- R10: After idle_i falls the block is in bypass mode, and the first clk_o edge comes within 10 reference cycles.
- R11: Lock is never reported while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| syn_clk_i | input | 1 | Synthesized clock from the oscillator |
| idle_i | input | 1 | Idle request; high stops the output |
| wr_i | input | 1 | Control word write strobe |
| wdata_i | input | 12 | Control word write data |
| rdata_o | output | 12 | Control word readback including lock |
| lock_o | output | 1 | Lock status |
| clk_o | output | 1 | Gated output clock |

## Verification
A corrupted lock counter shows on lock_o and readback bit 11 as a rise one or more cycles early or late. The scoreboard catches this on the exact cycle, because every cycle of the acquisition window is compared. A sequencer stuck in the wrong state shows as the wrong number of clk_o edges within a 40-cycle window, found at most about a dozen cycles after the mode change. Lost idle handling shows as clk_o edges during idle or a late first edge after release. A gate overlap is flagged on the reference edge where both gates are seen open.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int REG_W  = 12;
  localparam int EN_BIT = 0;
  localparam int BD_LSB = 1;
  localparam int BD_W   = 2;
  localparam int M_LSB  = 3;
  localparam int M_W    = 5;
  localparam int N_LSB  = 8;
  localparam int N_W    = 3;
  localparam int N_MAX  = 4;
  localparam int LK_BIT = 11;

  typedef enum logic [1:0] {SW_BYP, SW_B2S, SW_SYN, SW_S2B} sw_state_e;
endpackage

// File: rtl/pllc_sync.sv
module pllc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pllc_regs.sv
module pllc_regs import pllc_pkg::*; #(
  parameter int LOCK_CYCLES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             en_o,
  output logic [BD_W-1:0]  bd_o,
  output logic [M_W-1:0]   m_o,
  output logic [N_W-1:0]   n_o,
  output logic             lock_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic           acc;
  logic [M_W-1:0] m_w;
  logic [N_W-1:0] n_w;
  logic [CW-1:0]  cnt_q;
  logic           unused_lk;

  assign unused_lk = wdata_i[LK_BIT];
  assign acc       = wr_i && !idle_i;

  always_comb begin
    m_w = wdata_i[M_LSB +: M_W];
    if (m_w == '0) m_w = M_W'(1);
    n_w = wdata_i[N_LSB +: N_W];
    if (n_w == '0)                n_w = N_W'(1);
    else if (n_w > N_W'(N_MAX))   n_w = N_W'(N_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
      bd_o <= '0;
      m_o  <= M_W'(1);
      n_o  <= N_W'(1);
    end else if (idle_i) begin
      en_o <= 1'b0;
    end else if (acc) begin
      en_o <= wdata_i[EN_BIT];
      bd_o <= wdata_i[BD_LSB +: BD_W];
      m_o  <= m_w;
      n_o  <= n_w;
    end
  end

  // any accepted write restarts acquisition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      cnt_q  <= '0;
    end else if (idle_i || acc) begin
      lock_o <= 1'b0;
      cnt_q  <= '0;
    end else if (en_o && !lock_o) begin
      if (cnt_q == CW'(LOCK_CYCLES - 1)) lock_o <= 1'b1;
      else                               cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pllc_bypdiv.sv
module pllc_bypdiv import pllc_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [BD_W-1:0] bd_i,
  output logic            byp_clk_o,
  output logic            safe_o
);
  logic [1:0] cnt_q;
  logic       div_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign div_bit   = bd_i[1] ? cnt_q[1] : cnt_q[0];
  assign byp_clk_o = (bd_i == '0) ? clk_i : div_bit;
  // divided clock is a flop output: gate may change only in its low cycle
  assign safe_o    = (bd_i == '0) || !div_bit;
endmodule

// File: rtl/pllc_switch.sv
module pllc_switch import pllc_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic syn_clk_i,
  input  logic idle_i,
  input  logic want_syn_i,
  input  logic byp_clk_i,
  input  logic byp_safe_i,
  output logic byp_gate_o,
  output logic syn_gate_o,
  output logic clk_o
);
  sw_state_e st_q, st_d;
  logic      syn_req_q, syn_req_s, syn_ack, byp_req;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SW_BYP:  if (want_syn_i && byp_gate_o) st_d = SW_B2S;
      SW_B2S:  if (!byp_gate_o)              st_d = SW_SYN;
      SW_SYN:  if (!want_syn_i && syn_ack)   st_d = SW_S2B;
      SW_S2B:  if (!syn_ack)                 st_d = SW_BYP;
      default:                               st_d = SW_BYP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SW_BYP;
      syn_req_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      syn_req_q <= (st_d == SW_SYN);
    end
  end

  assign byp_req = (st_q == SW_BYP) && !idle_i;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         byp_gate_o <= 1'b0;
    else if (byp_safe_i) byp_gate_o <= byp_req;
  end

  pllc_sync #(.STAGES(2)) u_req_sync (
    .clk_i(syn_clk_i), .rst_ni(rst_ni), .d_i(syn_req_q), .q_o(syn_req_s)
  );

  always_ff @(negedge syn_clk_i or negedge rst_ni) begin
    if (!rst_ni) syn_gate_o <= 1'b0;
    else         syn_gate_o <= syn_req_s;
  end

  pllc_sync #(.STAGES(2)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(syn_gate_o), .q_o(syn_ack)
  );

  assign clk_o = (byp_clk_i & byp_gate_o) | (syn_clk_i & syn_gate_o);
endmodule

// File: rtl/pllc_top.sv
module pllc_top import pllc_pkg::*; #(
  parameter int LOCK_CYCLES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             syn_clk_i,
  input  logic             idle_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             lock_o,
  output logic             clk_o
);
  logic            en, lock, byp_clk, byp_safe, byp_gate, syn_gate;
  logic [BD_W-1:0] bd;
  logic [M_W-1:0]  m;
  logic [N_W-1:0]  n;

  pllc_regs #(.LOCK_CYCLES(LOCK_CYCLES)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .en_o(en), .bd_o(bd), .m_o(m), .n_o(n), .lock_o(lock)
  );

  pllc_bypdiv u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .bd_i(bd),
    .byp_clk_o(byp_clk), .safe_o(byp_safe)
  );

  pllc_switch u_sw (
    .clk_i(clk_i), .rst_ni(rst_ni), .syn_clk_i(syn_clk_i), .idle_i(idle_i),
    .want_syn_i(en && lock), .byp_clk_i(byp_clk), .byp_safe_i(byp_safe),
    .byp_gate_o(byp_gate), .syn_gate_o(syn_gate), .clk_o(clk_o)
  );

  always_comb begin
    rdata_o                 = '0;
    rdata_o[EN_BIT]         = en;
    rdata_o[BD_LSB +: BD_W] = bd;
    rdata_o[M_LSB +: M_W]   = m;
    rdata_o[N_LSB +: N_W]   = n;
    rdata_o[LK_BIT]         = lock;
  end

  assign lock_o = lock;
endmodule

// File: rtl/pllc_chk.sv
module pllc_chk import pllc_pkg::*; #(
  parameter int LOCK_CYCLES = 20
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           idle_i,
  input logic           wr_i,
  input logic           wr_en,
  input logic           en_q,
  input logic [M_W-1:0] m_q,
  input logic [N_W-1:0] n_q,
  input logic           lock_o,
  input logic           byp_gate,
  input logic           syn_gate
);
  localparam int CW = $clog2(LOCK_CYCLES + 2);
  logic [CW-1:0] acq_q;

  // cycles spent enabled and unlocked since the last restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                acq_q <= '0;
    else if (idle_i || wr_i || !en_q || lock_o) acq_q <= '0;
    else if (acq_q != {CW{1'b1}})               acq_q <= acq_q + 1'b1;
  end

  a_r4_lock_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> acq_q == CW'(LOCK_CYCLES));
  a_r6_write_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_en) |=> !lock_o);
  a_r7_clear_drops_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_en) |=> !lock_o);
  a_r8_gates_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byp_gate && syn_gate));
  a_r9_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> (!lock_o && !en_q));
  a_r11_lock_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> en_q);
  a_r3_fields_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_q != '0) && (n_q != '0) && (n_q <= N_W'(N_MAX)));
endmodule

bind pllc_top pllc_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle_i), .wr_i(wr_i),
  .wr_en(wdata_i[pllc_pkg::EN_BIT]), .en_q(rdata_o[pllc_pkg::EN_BIT]),
  .m_q(rdata_o[pllc_pkg::M_LSB +: pllc_pkg::M_W]),
  .n_q(rdata_o[pllc_pkg::N_LSB +: pllc_pkg::N_W]),
  .lock_o(lock_o), .byp_gate(byp_gate), .syn_gate(syn_gate)
);

// File: tb/tb_pllc_top.sv
`timescale 1ns/1ps
module tb_pllc_top;
  import pllc_pkg::*;
  localparam int LOCK = 20;

  logic             clk_i = 1'b0, syn_clk = 1'b0, rst_ni = 1'b0;
  logic             idle = 1'b0, wr = 1'b0;
  logic [REG_W-1:0] wdata = '0;
  logic [REG_W-1:0] rdata;
  logic             lock, clk_o;

  always #4   clk_i   = ~clk_i;   // 125 MHz reference
  always #2.5 syn_clk = ~syn_clk; // 200 MHz synthesized

  pllc_top #(.LOCK_CYCLES(LOCK)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .syn_clk_i(syn_clk), .idle_i(idle),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .lock_o(lock), .clk_o(clk_o)
  );

  int checks = 0, fails = 0, cyc = 0, edges = 0;

  always @(posedge clk_i) cyc <= cyc + 1;
  always @(posedge clk_o) edges++;

  typedef struct {int due; logic [REG_W-1:0] val; string tag;} exp_t;
  exp_t sb[$];

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // monitor: compare readback against queued expectations
  always @(negedge clk_i) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, rdata, e.val);
    end
  end

  // driver: write, expect e_now for n_hold cycles, then e_after
  task automatic write(logic [REG_W-1:0] v, logic [REG_W-1:0] e_now,
                       int n_hold, logic [REG_W-1:0] e_after, string tag);
    @(posedge clk_i); #1;
    wr = 1'b1; wdata = v;
    for (int i = 1; i <= n_hold; i++) sb.push_back('{cyc + i, e_now, tag});
    sb.push_back('{cyc + n_hold + 1, e_after, tag});
    @(posedge clk_i); #1;
    wr = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic count(string tag, int exp);
    int n0, d, tol;
    @(posedge clk_i); #1;
    n0 = edges;
    repeat (40) @(posedge clk_i);
    #1;
    d   = edges - n0;
    tol = (exp == 0) ? 0 : 1;
    checks++;
    if (d < exp - tol || d > exp + tol) begin
      fails++;
      $display("FAIL %s: got %0d clk_o edges expected %0d", tag, d, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n0, waited;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk("R1 reset word", rdata, 12'h108);
    chk("R1 reset lock", lock, 0);
    wait_cyc(5);
    count("R1 reset bypass rate", 40);

    write(12'h10A, 12'h10A, 1, 12'h10A, "R2 div2 word");
    wait_cyc(6);
    count("R2 bypass div2", 20);
    write(12'h10C, 12'h10C, 1, 12'h10C, "R2 div4 word");
    wait_cyc(6);
    count("R2 bypass div4", 10);

    write(12'h000, 12'h108, 1, 12'h108, "R3 zero clamp");
    write(12'h7F8, 12'h4F8, 1, 12'h4F8, "R3 n high clamp");

    // enable: m=31 n=4
    write(12'h4F9, 12'h4F9, LOCK, 12'hCF9, "R4 lock delay");
    wait_cyc(LOCK + 12);
    count("R5 R8 synthesized only", 64);

    write(12'h219, 12'h219, LOCK, 12'hA19, "R6 rewrite restart");
    wait_cyc(LOCK + 12);
    count("R5 synthesized after relock", 64);

    write(12'h21A, 12'h21A, 1, 12'h21A, "R7 clear enable");
    wait_cyc(12);
    count("R7 back to div2", 20);
    wait_cyc(30);
    chk("R11 no lock while disabled", lock, 0);

    write(12'h219, 12'h219, LOCK, 12'hA19, "R6 enable again");
    wait_cyc(LOCK + 12);

    @(posedge clk_i); #1;
    idle = 1'b1;
    sb.push_back('{cyc + 1, 12'h218, "R9 idle clears"});
    wait_cyc(12);
    count("R9 no clock in idle", 0);
    write(12'h0F1, 12'h218, 1, 12'h218, "R9 idle write ignored");
    chk("R9 idle lock", lock, 0);

    @(posedge clk_i); #1;
    idle   = 1'b0;
    n0     = edges;
    waited = 0;
    while (edges == n0 && waited < 20) begin
      @(negedge clk_i);
      waited++;
    end
    checks++;
    if (edges == n0 || waited > 10) begin
      fails++;
      $display("FAIL R10 idle exit: got %0d cycles expected <= 10", waited);
    end
    chk("R10 bypass after idle", rdata, 12'h218);
    wait_cyc(4);
    count("R10 bypass rate after idle", 40);

    wait_cyc(2);
    chk("R4 scoreboard drained", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule